// File: doc/BRIEF.md
# Manchester Bit Decoder with Sync Recognition

This block turns a Manchester II coded serial line into NRZ data and a 1x recovered bit clock. It runs from a sampling clock at `OSR` times the bit rate; `OSR` is 16 by default. The coded line arrives in one of two ways. One way is a complementary pair of zero and one rails. The other is a single unipolar rail, and the rails that are not in use are parked at fixed levels. A small digital PLL puts a half-bit phase counter back into step on every line transition. It samples the line once per half-bit. The sampled half-bit symbols go through a short window, where sync patterns are found and bit cells are checked for a mid-cell transition.

The block recognises two sync patterns, each three bit times long: a command sync and a data sync. It holds a validity flag that needs a sync followed by two clean bits before it rises. It also drives a reset output whose behaviour depends on an operating-mode input. In converter mode that output follows the reset input. In repeater mode it stays low until the first bit after a sync arrives as a zero. In repeater mode the block also reports which kind of sync came last.

Top module: `mdec_decoder`

## Requirements
- R1: The coded line seen by the decoder is `udi_i | (boi_i & ~bzi_i)`. In unipolar use `bzi_i`=1 and `boi_i`=0. In bipolar use `udi_i`=0 and `bzi_i`=`~boi_i`. Both paths decode identically.
- R2: A bit cell lasts `OSR` samples as two halves of `OSR/2` samples each; a 1 is high then low and a 0 is low then high. Each decoded bit appears on `sdo_o` on the same clock edge at which `dclk_o` rises. `dclk_o` then stays high for one half-bit and falls at the next half-bit sample.
- R3: A command sync is three half-bits high followed by three low. A data sync is three low followed by three high. Data bits start right after the sync, with bit 0 first.
- R4: Every run of equal levels may be up to 2 samples shorter or longer than its nominal length and still decode correctly, because each transition realigns the sampling phase.
- R5: A bit cell whose two halves are equal is a code violation; this includes a line with no transitions. On a violation `valid_o` and `sdo_o` go low and `dclk_o` stops until a new sync is found.
- R6: `valid_o` is low after reset. It rises together with the `dclk_o` rise of the second clean bit after a sync, and it stays high across later clean bits.
- R7: While `rst_ni` is low, `sdo_o`, `valid_o` and `dclk_o` are low.
- R8: When `repeater_i`=1, `sync_cmd_o` is 1 after a command sync and 0 after a data sync. When `repeater_i`=0 it is 0.
- R9: When `repeater_i`=0, `srst_o` equals `rst_ni`.
- R10: When `repeater_i`=1, `srst_o` goes low with reset and stays low after release. It goes high only after the first bit following a sync has been decoded clean as 0. If that first bit is 1, `srst_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock, OSR times the bit rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| repeater_i | input | 1 | 1 selects repeater mode, 0 selects converter mode |
| bzi_i | input | 1 | Bipolar zero rail |
| boi_i | input | 1 | Bipolar one rail |
| udi_i | input | 1 | Unipolar coded rail |
| sdo_o | output | 1 | Decoded NRZ data |
| dclk_o | output | 1 | Recovered 1x bit clock |
| valid_o | output | 1 | Decoded data valid |
| sync_cmd_o | output | 1 | Type of last sync, repeater mode only |
| srst_o | output | 1 | Sequenced reset output |

## Verification
Suppose the phase counter drifts or the bit-slot counter lands on the wrong cell boundary. The first bit after the sync then shows up as a wrong `sdo_o` value or a missing `dclk_o` rise, one and a half bit times after that bit ends, and the frame's `valid_o` drops. A stale lock or a stale good-bit count shows up at the end of each frame: the bench expects `valid_o`, `sdo_o` and `dclk_o` to be low within ten idle half-bits. A wrong latched sync type or reset-bit state shows up on `sync_cmd_o` at the very next decoded bit, and on `srst_o` once the frame has ended.

// File: rtl/mdec_pkg.sv
package mdec_pkg;
  localparam int unsigned SYNC_LEN = 6;  // half-bits in a sync pattern
  localparam logic [SYNC_LEN-1:0] CMD_SYNC  = 6'b111000;
  localparam logic [SYNC_LEN-1:0] DATA_SYNC = 6'b000111;
  localparam logic [SYNC_LEN-2:0] SHIFT_INIT = 5'b01010;  // cannot complete a sync
endpackage

// File: rtl/mdec_front.sv
module mdec_front #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bzi_i,
  input  logic boi_i,
  input  logic udi_i,
  output logic line_o,
  output logic edge_o
);
  logic                   raw;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   line_q;

  // parked rails contribute nothing in either input style
  assign raw = udi_i | (boi_i & ~bzi_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      line_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
      line_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign line_o = sync_q[SYNC_STAGES-1];
  assign edge_o = line_o ^ line_q;
endmodule

// File: rtl/mdec_dpll.sv
module mdec_dpll #(
  parameter int unsigned OSR = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic edge_i,
  output logic strobe_o
);
  localparam int unsigned HALF = OSR / 2;
  localparam int unsigned PW   = (HALF > 2) ? $clog2(HALF) : 1;
  localparam logic [PW-1:0] LAST = PW'(HALF - 1);
  localparam logic [PW-1:0] MID  = PW'(HALF / 2);

  logic [PW-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          phase_q <= '0;
    else if (edge_i)      phase_q <= PW'(1);
    else if (phase_q == LAST) phase_q <= '0;
    else                  phase_q <= phase_q + PW'(1);
  end

  assign strobe_o = (phase_q == MID);

  if (HALF > 2) begin : g_chk
    assert_strobe_gap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      strobe_o |=> !strobe_o);
  end
endmodule

// File: rtl/mdec_pattern.sv
module mdec_pattern import mdec_pkg::*; #(
  parameter int unsigned VALID_BITS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  input  logic line_i,
  output logic sdo_o,
  output logic dclk_o,
  output logic valid_o,
  output logic cmd_o,
  output logic rbit_zero_o
);
  localparam int unsigned GW  = $clog2(VALID_BITS + 1);
  localparam int unsigned EVW = $clog2(SYNC_LEN);
  localparam logic [EVW-1:0] EV_RELOAD = EVW'(SYNC_LEN - 1);

  logic [SYNC_LEN-2:0] sh_q;
  logic [SYNC_LEN-1:0] win;
  logic [EVW-1:0]      ev_q;
  logic [GW-1:0]       good_q;
  logic locked_q, dclk_q, sdo_q, valid_q, cmd_q, first_q, rbz_q;
  logic is_cmd, is_dat;

  assign win    = {sh_q, line_i};
  assign is_cmd = (win == CMD_SYNC);
  assign is_dat = (win == DATA_SYNC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= SHIFT_INIT;
      ev_q     <= '0;
      good_q   <= '0;
      locked_q <= 1'b0;
      dclk_q   <= 1'b0;
      sdo_q    <= 1'b0;
      valid_q  <= 1'b0;
      cmd_q    <= 1'b0;
      first_q  <= 1'b0;
      rbz_q    <= 1'b0;
    end else begin
      rbz_q <= 1'b0;
      if (strobe_i) begin
        sh_q   <= win[SYNC_LEN-2:0];
        dclk_q <= 1'b0;
        if (is_cmd || is_dat) begin
          // sync wins over any pending cell decision
          locked_q <= 1'b1;
          ev_q     <= EV_RELOAD;
          cmd_q    <= is_cmd;
          first_q  <= 1'b1;
          good_q   <= '0;
        end else if (locked_q) begin
          if (ev_q != '0) begin
            ev_q <= ev_q - EVW'(1);
          end else begin
            ev_q <= EVW'(1);
            // cell sits in the oldest two window slots
            if (win[SYNC_LEN-1] != win[SYNC_LEN-2]) begin
              dclk_q  <= 1'b1;
              sdo_q   <= win[SYNC_LEN-1];
              first_q <= 1'b0;
              rbz_q   <= first_q & ~win[SYNC_LEN-1];
              if (good_q != GW'(VALID_BITS)) good_q <= good_q + GW'(1);
              if (good_q >= GW'(VALID_BITS - 1)) valid_q <= 1'b1;
            end else begin
              locked_q <= 1'b0;
              valid_q  <= 1'b0;
              sdo_q    <= 1'b0;
              good_q   <= '0;
              first_q  <= 1'b0;
            end
          end
        end
      end
    end
  end

  assign sdo_o       = sdo_q;
  assign dclk_o      = dclk_q;
  assign valid_o     = valid_q;
  assign cmd_o       = cmd_q;
  assign rbit_zero_o = rbz_q;

  assert_valid_locked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> locked_q);
  assert_valid_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_q) |-> $rose(dclk_q));
  assert_violation_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(locked_q) |-> (!valid_q && !sdo_q && !dclk_q));
  assert_dclk_half_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dclk_q && strobe_i) |=> !dclk_q);
  assert_dclk_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dclk_q && !strobe_i) |=> dclk_q);
endmodule

// File: rtl/mdec_decoder.sv
module mdec_decoder #(
  parameter int unsigned OSR         = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned VALID_BITS  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic repeater_i,
  input  logic bzi_i,
  input  logic boi_i,
  input  logic udi_i,
  output logic sdo_o,
  output logic dclk_o,
  output logic valid_o,
  output logic sync_cmd_o,
  output logic srst_o
);
  logic line, edge_s, strobe, cmd, rbit_zero;
  logic srst_q;

  mdec_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk_i, .rst_ni, .bzi_i, .boi_i, .udi_i,
    .line_o(line), .edge_o(edge_s)
  );

  mdec_dpll #(.OSR(OSR)) u_dpll (
    .clk_i, .rst_ni, .edge_i(edge_s), .strobe_o(strobe)
  );

  mdec_pattern #(.VALID_BITS(VALID_BITS)) u_pattern (
    .clk_i, .rst_ni, .strobe_i(strobe), .line_i(line),
    .sdo_o, .dclk_o, .valid_o, .cmd_o(cmd), .rbit_zero_o(rbit_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        srst_q <= 1'b0;
    else if (rbit_zero) srst_q <= 1'b1;
  end

  assign srst_o     = repeater_i ? srst_q : rst_ni;
  assign sync_cmd_o = repeater_i & cmd;

  assert_srst_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(srst_q) |-> $past(rbit_zero));
endmodule

// File: tb/tb_mdec_decoder.sv
module tb_mdec_decoder;
  localparam int OSR  = 16;
  localparam int HALF = OSR / 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic repeater = 1'b0;
  logic bzi = 1'b1, boi = 1'b0, udi = 1'b0;
  logic sdo, dclk, valid, sync_cmd, srst;

  int n_chk = 0;
  int n_fail = 0;
  bit uni = 1'b1;
  bit exp_srst = 1'b0;
  bit done = 1'b0;

  bit obs_sdo[$];
  bit obs_val[$];
  bit obs_cmd[$];
  logic dclk_prev = 1'b0;

  always #5 clk = ~clk;

  mdec_decoder #(.OSR(OSR)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .repeater_i(repeater),
    .bzi_i(bzi), .boi_i(boi), .udi_i(udi),
    .sdo_o(sdo), .dclk_o(dclk), .valid_o(valid),
    .sync_cmd_o(sync_cmd), .srst_o(srst)
  );

  // capture outputs on each recovered clock rise, away from the clk edge
  always @(negedge clk) begin
    if (dclk && !dclk_prev) begin
      obs_sdo.push_back(sdo);
      obs_val.push_back(valid);
      obs_cmd.push_back(sync_cmd);
    end
    dclk_prev = dclk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic set_line(input bit v);
    if (uni) begin bzi = 1'b1; boi = 1'b0; udi = v; end   // R1 unipolar
    else     begin bzi = ~v;   boi = v;    udi = 1'b0; end // R1 bipolar
  endtask

  task automatic drive_frame(input bit cmd, input int nbits, input logic [31:0] data,
                             input int viol_at, input bit jit);
    bit hv[$];
    int i;
    if (cmd) hv = '{1, 1, 1, 0, 0, 0};
    else     hv = '{0, 0, 0, 1, 1, 1};
    for (int b = 0; b < nbits; b++) begin
      if (b == viol_at) begin
        bit v = ~hv[hv.size()-1];
        hv.push_back(v); hv.push_back(v);
      end else begin
        hv.push_back(data[b]); hv.push_back(~data[b]);
      end
    end
    for (int k = 0; k < 10; k++) hv.push_back(hv[hv.size()-1]);
    i = 0;
    while (i < hv.size()) begin
      int n = 1;
      int len;
      while (i + n < hv.size() && hv[i+n] == hv[i]) n++;
      len = HALF * n;
      if (jit && (i + n < hv.size())) len += int'($urandom_range(0, 4)) - 2;
      repeat (len) begin
        set_line(hv[i]);
        @(negedge clk);
      end
      i += n;
    end
  endtask

  task automatic clear_obs();
    obs_sdo.delete(); obs_val.delete(); obs_cmd.delete();
  endtask

  task automatic run_frame(input bit cmd, input int nbits, input logic [31:0] data,
                           input int viol_at, input bit jit);
    int n_obs;
    string tag;
    tag = jit ? "R4" : (uni ? "R1" : "R2");
    clear_obs();
    drive_frame(cmd, nbits, data, viol_at, jit);
    n_obs = (viol_at < 0) ? nbits : viol_at;
    chk(obs_sdo.size() == n_obs, "R3 R5 decoded bit count", obs_sdo.size(), n_obs);
    for (int i = 0; i < n_obs && i < obs_sdo.size(); i++) begin
      chk(obs_sdo[i] == data[i], {tag, " sdo"}, obs_sdo[i], data[i]);
      chk(obs_val[i] == (i >= 1), "R6 valid at bit", obs_val[i], int'(i >= 1));
      chk(obs_cmd[i] == (repeater & cmd), "R8 sync type", obs_cmd[i], int'(repeater & cmd));
    end
    // idle tail ends every frame with a violation
    chk(valid == 1'b0, "R5 valid after idle", valid, 0);
    chk(sdo == 1'b0, "R5 sdo after idle", sdo, 0);
    chk(dclk == 1'b0, "R5 dclk after idle", dclk, 0);
    if (repeater) begin
      if (n_obs >= 1 && !data[0]) exp_srst = 1'b1;
      chk(srst == exp_srst, "R10 srst", srst, exp_srst);
    end else begin
      chk(srst == 1'b1, "R9 srst follows reset", srst, 1);
    end
  endtask

  task automatic rand_frames(input int count);
    for (int f = 0; f < count; f++) begin
      bit cmd = 1'($urandom_range(0, 1));
      int nb = int'($urandom_range(2, 16));
      logic [31:0] d = $urandom;
      int va = ($urandom_range(0, 3) == 0 && nb > 2) ? int'($urandom_range(1, nb - 1)) : -1;
      bit jit = 1'($urandom_range(0, 1));
      uni = 1'($urandom_range(0, 1));
      run_frame(cmd, nb, d, va, jit);
    end
  endtask

  task automatic do_reset(input bit rep);
    @(negedge clk);
    rst_ni = 1'b0;
    repeater = rep;
    repeat (3) @(negedge clk);
    chk(sdo == 1'b0, "R7 sdo in reset", sdo, 0);
    chk(valid == 1'b0, "R7 valid in reset", valid, 0);
    chk(dclk == 1'b0, "R7 dclk in reset", dclk, 0);
    chk(srst == 1'b0, rep ? "R10 srst in reset" : "R9 srst in reset", srst, 0);
    rst_ni = 1'b1;
    exp_srst = 1'b0;
    repeat (2) @(negedge clk);
    if (rep) chk(srst == 1'b0, "R10 srst held after release", srst, 0);
    else     chk(srst == 1'b1, "R9 srst after release", srst, 1);
    chk(valid == 1'b0, "R6 valid after reset", valid, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    set_line(1'b0);
    do_reset(1'b0);
    repeat (40) @(negedge clk);

    // converter mode: shortest frame, then violation on bit 1
    uni = 1'b1;
    run_frame(1'b1, 2, 32'h2, -1, 1'b0);
    run_frame(1'b0, 8, 32'hA5, 1, 1'b0);
    uni = 1'b0;
    run_frame(1'b1, 16, 32'hC3F0, -1, 1'b0);
    rand_frames(20);

    // repeater mode: reset bit 1 keeps srst low, reset bit 0 releases it
    do_reset(1'b1);
    uni = 1'b1;
    run_frame(1'b1, 6, 32'h3F, -1, 1'b0);
    run_frame(1'b0, 6, 32'h2A, -1, 1'b0);
    run_frame(1'b0, 4, 32'h5, -1, 1'b1);
    rand_frames(20);

    // R7: reset pulse in the middle of a frame
    clear_obs();
    fork
      drive_frame(1'b1, 16, 32'h1234, -1, 1'b0);
      begin
        repeat (150) @(negedge clk);
        rst_ni = 1'b0;
        @(negedge clk);
        chk(sdo == 1'b0, "R7 sdo forced low", sdo, 0);
        chk(valid == 1'b0, "R7 valid low", valid, 0);
        chk(dclk == 1'b0, "R7 dclk low", dclk, 0);
        chk(srst == 1'b0, "R10 srst low in reset", srst, 0);
        repeat (2) @(negedge clk);
        rst_ni = 1'b1;
      end
    join
    exp_srst = 1'b0;
    chk(obs_sdo.size() >= 1, "R7 bits before reset pulse", obs_sdo.size(), 1);
    chk(valid == 1'b0, "R6 valid after mid reset", valid, 0);
    chk(srst == 1'b0, "R10 srst after mid reset", srst, 0);
    run_frame(1'b0, 5, 32'h1A, -1, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule